// File: doc/BRIEF.md
# Timer Output Compare Mode Generator

This block produces the reference waveform of one output compare channel of a general purpose timer. Each clock it looks at the shared counter value, the count direction, and the channel's compare value. A 4-bit mode code then chooses the next reference level:

- hold the current level;
- set, clear or toggle it on a compare match;
- force it low or high;
- follow a direction-aware PWM comparison in either polarity;
- run a retriggerable one-pulse sequence that an external trigger starts and an update event ends.

A second output, the combined reference, serves centre-aligned and phase-shifted PWM. It joins this channel's reference with a companion channel's reference by OR or AND, or it picks one of the two by count direction. The counter, dead-time, polarity and output-enable stages sit outside the block.

Top module: `ocref_gen`

## Requirements
- R1: A synchronous reset drives `oc_ref` low and disarms the one-pulse sequence. `oc_ref` is a register: a condition present in one cycle shows on the output after the next rising clock edge.
- R2: With mode 0, or with the reserved codes 10 and 11, `oc_ref` keeps its level whatever the counter does.
- R3: When `cnt == cmp_val`, mode 1 sets `oc_ref`, mode 2 clears it and mode 3 inverts it. Without equality, these modes hold the level.
- R4: Mode 4 forces `oc_ref` low and mode 5 forces it high.
- R5: Mode 6 (PWM 1) depends on `cnt_down`. Counting up (`cnt_down` = 0), `oc_ref` goes high when `cnt < cmp_val` and low otherwise. Counting down (`cnt_down` = 1), it goes low when `cnt > cmp_val` and high otherwise.
- R6: Mode 7 (PWM 2) produces the inverse of the mode 6 level under the same inputs.
- R7: In mode 8 the reference has an idle level: high counting up, low counting down. It holds that level until a `trig_pulse` arms the sequence. While armed it follows PWM 1. An `upd_pulse` disarms it and returns it to the idle level.
- R8: Mode 9 works like mode 8 with the opposite idle level (low counting up, high counting down), and it follows PWM 2 while armed.
- R9: A trigger and an update in the same cycle leave the sequence disarmed. The reference then takes the idle level. A trigger takes effect at the same edge it is sampled.
- R10: Modes 12 and 13 drive `oc_ref` as PWM 1 and PWM 2. `oc_refc` is `oc_ref | partner_ref` in mode 12 and `oc_ref & partner_ref` in mode 13.
- R11: Modes 14 and 15 drive `oc_ref` as PWM 1 and PWM 2. `oc_refc` equals `oc_ref` while `cnt_down` is 0 and `partner_ref` while it is 1.
- R12: In all modes from 0 to 11, `oc_refc` equals `oc_ref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| upd_pulse | input | 1 | Update event, one cycle |
| trig_pulse | input | 1 | External trigger, one cycle |
| cmp_val | input | CNT_W | Channel compare value |
| mode | input | 4 | Output compare mode code |
| partner_ref | input | 1 | Companion channel reference level |
| oc_ref | output | 1 | Channel reference, registered |
| oc_refc | output | 1 | Combined reference |

## Verification
The hardest state to reach is the armed one-pulse sequence at the moment an update arrives, and in particular a trigger that lands in the same cycle as an update. The stimulus runs modes 8 and 9 in both count directions. It spaces triggers and updates on different periods so that they sometimes coincide. It also sends a dedicated burst in which the trigger and the update are sent together. Before the hold and match modes run, forced modes set a known level, so that a level that is held can be told apart from one that is reset.

// File: rtl/ocref_pkg.sv
package ocref_pkg;
   typedef enum logic [3:0] {
      OM_HOLD     = 4'd0,
      OM_SET_EQ   = 4'd1,
      OM_CLR_EQ   = 4'd2,
      OM_TGL_EQ   = 4'd3,
      OM_LOW      = 4'd4,
      OM_HIGH     = 4'd5,
      OM_PWM_A    = 4'd6,
      OM_PWM_B    = 4'd7,
      OM_PULSE_A  = 4'd8,
      OM_PULSE_B  = 4'd9,
      OM_RSV0     = 4'd10,
      OM_RSV1     = 4'd11,
      OM_PAIR_OR  = 4'd12,
      OM_PAIR_AND = 4'd13,
      OM_SKEW_A   = 4'd14,
      OM_SKEW_B   = 4'd15
   } oc_mode_e;

   function automatic logic is_pwm_b(input oc_mode_e m);
      return (m == OM_PWM_B) || (m == OM_PAIR_AND) || (m == OM_SKEW_B);
   endfunction
endpackage

// File: rtl/ocref_cmp.sv
module ocref_cmp #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cnt_down,
   output logic             eq,
   output logic             pwm_a
);
   logic lt, gt;
   always_comb begin
      eq    = (cnt == cmp_val);
      lt    = (cnt <  cmp_val);
      gt    = (cnt >  cmp_val);
      pwm_a = cnt_down ? !gt : lt;
   end
endmodule

// File: rtl/ocref_opm.sv
module ocref_opm (
   input  logic clk,
   input  logic rst,
   input  logic upd_pulse,
   input  logic trig_pulse,
   output logic armed_nxt,
   output logic armed
);
   always_comb begin
      if (upd_pulse)       armed_nxt = 1'b0;
      else if (trig_pulse) armed_nxt = 1'b1;
      else                 armed_nxt = armed;
   end

   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b0;
      else     armed <= armed_nxt;
   end

   p_upd_disarms_r9: assert property (@(posedge clk) disable iff (rst)
      upd_pulse |=> !armed);
   p_trig_arms_r7: assert property (@(posedge clk) disable iff (rst)
      (trig_pulse && !upd_pulse) |=> armed);
endmodule

// File: rtl/ocref_pair.sv
module ocref_pair
   import ocref_pkg::*;
#(
   parameter bit HAS_PAIR = 1'b1
) (
   input  oc_mode_e mode,
   input  logic     cnt_down,
   input  logic     own_ref,
   input  logic     partner_ref,
   output logic     refc
);
   generate
      if (HAS_PAIR) begin : g_pair
         always_comb begin
            unique case (mode)
               OM_PAIR_OR:           refc = own_ref | partner_ref;
               OM_PAIR_AND:          refc = own_ref & partner_ref;
               OM_SKEW_A, OM_SKEW_B: refc = cnt_down ? partner_ref : own_ref;
               default:              refc = own_ref;
            endcase
         end
      end else begin : g_single
         logic unused_in;
         assign unused_in = cnt_down ^ partner_ref ^ (^mode);
         assign refc      = own_ref;
      end
   endgenerate
endmodule

// File: rtl/ocref_gen.sv
module ocref_gen
   import ocref_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit HAS_PAIR = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic             upd_pulse,
   input  logic             trig_pulse,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [3:0]       mode,
   input  logic             partner_ref,
   output logic             oc_ref,
   output logic             oc_refc
);
   localparam int MODE_W = $bits(oc_mode_e);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("ocref_gen: CNT_W must lie in 2..32");
      end
      if (MODE_W != 4) begin : g_bad_mode
         $error("ocref_gen: mode code must be 4 bits");
      end
   endgenerate

   oc_mode_e m;
   logic     eq, pwm_a, pwm_lvl, idle_lvl;
   logic     armed_nxt, armed;
   logic     ref_q, ref_d;

   assign m = oc_mode_e'(mode);

   ocref_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt      (cnt),
      .cmp_val  (cmp_val),
      .cnt_down (cnt_down),
      .eq       (eq),
      .pwm_a    (pwm_a)
   );

   ocref_opm u_opm (
      .clk        (clk),
      .rst        (rst),
      .upd_pulse  (upd_pulse),
      .trig_pulse (trig_pulse),
      .armed_nxt  (armed_nxt),
      .armed      (armed)
   );

   always_comb begin
      pwm_lvl  = is_pwm_b(m) ? !pwm_a : pwm_a;
      idle_lvl = (m == OM_PULSE_A) ? !cnt_down : cnt_down;
      unique case (m)
         OM_SET_EQ:  ref_d = eq ? 1'b1 : ref_q;
         OM_CLR_EQ:  ref_d = eq ? 1'b0 : ref_q;
         OM_TGL_EQ:  ref_d = eq ? !ref_q : ref_q;
         OM_LOW:     ref_d = 1'b0;
         OM_HIGH:    ref_d = 1'b1;
         OM_PWM_A, OM_PAIR_OR, OM_SKEW_A:  ref_d = pwm_a;
         OM_PWM_B, OM_PAIR_AND, OM_SKEW_B: ref_d = !pwm_a;
         OM_PULSE_A: ref_d = armed_nxt ? pwm_a  : idle_lvl;
         OM_PULSE_B: ref_d = armed_nxt ? !pwm_a : idle_lvl;
         default:    ref_d = ref_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ref_q <= 1'b0;
      else     ref_q <= ref_d;
   end

   assign oc_ref = ref_q;

   ocref_pair #(.HAS_PAIR(HAS_PAIR)) u_pair (
      .mode        (m),
      .cnt_down    (cnt_down),
      .own_ref     (ref_q),
      .partner_ref (partner_ref),
      .refc        (oc_refc)
   );

   p_reset_low_r1: assert property (@(posedge clk)
      rst |=> !oc_ref);
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd0 || mode == 4'd10 || mode == 4'd11) |=> $stable(oc_ref));
   p_set_on_match_r3: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd1 && cnt == cmp_val) |=> oc_ref);
   p_force_low_r4: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd4) |=> !oc_ref);
   p_force_high_r4: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd5) |=> oc_ref);
   p_pwm_up_r5: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd6 && !cnt_down && cnt < cmp_val) |=> oc_ref);
   p_both_pulses_r9: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd8 && upd_pulse && trig_pulse) |=> (oc_ref == !$past(cnt_down)));
   p_and_pair_r10: assert property (@(posedge clk) disable iff (rst)
      (mode == 4'd13 && !partner_ref) |-> !oc_refc);
   p_plain_refc_r12: assert property (@(posedge clk) disable iff (rst)
      (mode < 4'd12) |-> (oc_refc == oc_ref));
endmodule

// File: tb/ocref_gen_tb.sv
module ocref_gen_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] cnt = '0;
   logic         cnt_down = 1'b0;
   logic         upd_pulse = 1'b0;
   logic         trig_pulse = 1'b0;
   logic [W-1:0] cmp_val = 16'd5;
   logic [3:0]   mode = 4'd0;
   logic         partner_ref = 1'b0;
   logic         oc_ref, oc_refc;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit mdl_ref = 1'b0;
   bit mdl_armed = 1'b0;

   always #2 clk = ~clk;

   ocref_gen #(.CNT_W(W)) u_dut (
      .clk(clk), .rst(rst), .cnt(cnt), .cnt_down(cnt_down),
      .upd_pulse(upd_pulse), .trig_pulse(trig_pulse), .cmp_val(cmp_val),
      .mode(mode), .partner_ref(partner_ref),
      .oc_ref(oc_ref), .oc_refc(oc_refc)
   );

   function automatic bit pwm1(int c, int k, bit dn);
      if (dn) return !(c > k);
      return c < k;
   endfunction

   task automatic check(string req, string what, bit act, bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b (mode %0d cnt %0d)",
                  req, what, act, exp, mode, cnt);
      end
   endtask

   // Called at the falling edge with new inputs applied: check, then advance model.
   task automatic step(string req);
      bit exp_c, nxt_armed, lvl;
      int m, c, k;
      #1;
      m = mode; c = cnt; k = cmp_val;
      case (m)
         12: exp_c = mdl_ref | partner_ref;
         13: exp_c = mdl_ref & partner_ref;
         14, 15: exp_c = cnt_down ? partner_ref : mdl_ref;
         default: exp_c = mdl_ref;
      endcase
      check(req, "oc_ref", oc_ref, mdl_ref);
      check(m >= 12 ? req : "R12", "oc_refc", oc_refc, exp_c);
      nxt_armed = upd_pulse ? 1'b0 : (trig_pulse ? 1'b1 : mdl_armed);
      lvl = pwm1(c, k, cnt_down);
      case (m)
         1: if (c == k) mdl_ref = 1'b1;
         2: if (c == k) mdl_ref = 1'b0;
         3: if (c == k) mdl_ref = !mdl_ref;
         4: mdl_ref = 1'b0;
         5: mdl_ref = 1'b1;
         6, 12, 14: mdl_ref = lvl;
         7, 13, 15: mdl_ref = !lvl;
         8: mdl_ref = nxt_armed ? lvl : !cnt_down;
         9: mdl_ref = nxt_armed ? !lvl : cnt_down;
         default: ;
      endcase
      mdl_armed = nxt_armed;
      @(posedge clk);
      @(negedge clk);
   endtask

   // Sweep the counter 0..11 (or down) with periodic trigger/update/partner patterns.
   task automatic run(string req, int m, bit dn, int n, int tper, int uper);
      mode = 4'(m);
      cnt_down = dn;
      for (int i = 0; i < n; i++) begin
         cnt = dn ? 16'(11 - (i % 12)) : 16'(i % 12);
         trig_pulse = (tper > 0) && (i % tper == 3);
         upd_pulse  = (uper > 0) && (i % uper == 0);
         partner_ref = ((i / 3) % 2) == 1;
         step(req);
      end
      trig_pulse = 1'b0;
      upd_pulse  = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      repeat (3) @(negedge clk);
      check("R1", "oc_ref in reset", oc_ref, 1'b0);
      rst = 1'b0;
      mdl_ref = 1'b0;
      mdl_armed = 1'b0;
      // R1: armed flag cleared: mode 8 up with no trigger stays idle high
      run("R1", 8, 1'b0, 6, 0, 0);
      run("R4", 5, 1'b0, 4, 0, 0);
      run("R2", 0, 1'b0, 24, 5, 7);
      run("R2", 10, 1'b1, 12, 0, 0);
      run("R4", 4, 1'b0, 4, 0, 0);
      run("R2", 11, 1'b0, 12, 0, 0);
      run("R3", 1, 1'b0, 14, 0, 0);
      run("R3", 2, 1'b1, 14, 0, 0);
      run("R3", 3, 1'b0, 40, 0, 0);
      run("R3", 3, 1'b1, 30, 0, 0);
      run("R5", 6, 1'b0, 24, 0, 0);
      run("R5", 6, 1'b1, 24, 0, 0);
      cmp_val = 16'd0;
      run("R5", 6, 1'b0, 12, 0, 0);
      cmp_val = 16'd11;
      run("R5", 6, 1'b1, 12, 0, 0);
      cmp_val = 16'd5;
      run("R6", 7, 1'b0, 24, 0, 0);
      run("R6", 7, 1'b1, 24, 0, 0);
      run("R7", 8, 1'b0, 60, 9, 13);
      run("R7", 8, 1'b1, 60, 9, 13);
      run("R8", 9, 1'b0, 60, 7, 11);
      run("R8", 9, 1'b1, 60, 7, 11);
      // R9: trigger and update together, then trigger alone
      mode = 4'd8; cnt_down = 1'b0; cnt = 16'd9;
      trig_pulse = 1'b1; upd_pulse = 1'b1; step("R9");
      trig_pulse = 1'b0; upd_pulse = 1'b0; step("R9");
      trig_pulse = 1'b1; step("R9");
      trig_pulse = 1'b0; step("R9");
      upd_pulse = 1'b1; step("R9");
      upd_pulse = 1'b0; step("R9");
      run("R10", 12, 1'b0, 24, 0, 0);
      run("R10", 13, 1'b1, 24, 0, 0);
      run("R11", 14, 1'b0, 24, 0, 0);
      run("R11", 14, 1'b1, 24, 0, 0);
      run("R11", 15, 1'b1, 24, 0, 0);
      run("R11", 15, 1'b0, 24, 0, 0);
      run("R12", 3, 1'b1, 12, 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule